// File: doc/BRIEF.md
# Packed Vector Uniform Write Assembler

This block sits in front of the write port of a constant register file that holds 96 four-lane vectors, each lane a 24-bit float. Software pushes 32-bit data words one at a time on a write strobe. The block collects them until a full vector is present, and then issues one write to the file. The mode input selects how the words are read. In 32-bit float mode, each word is an IEEE single-precision value. It is narrowed to the 24-bit format, and four words make a vector. In packed mode, three words carry four 24-bit values back to back, and the block only slices them apart.

The destination entry comes from an internal index. An index load sets it and also discards any partly collected vector. After each committed vector the index steps forward by one, so a run of vectors fills consecutive entries. A vector aimed at an entry outside the file is dropped, and an error pulse is raised in its place.

The fill sequencer is a four-state machine:
- S_EMPTY holds no words.
- S_HAVE1, S_HAVE2 and S_HAVE3 hold one, two and three words.

An accepted word moves the machine one state forward. It returns to S_EMPTY in four cases:
- from S_HAVE2, when a word is accepted in packed mode (commit);
- from S_HAVE3, when a word is accepted in float mode (commit);
- from any state, on an index load;
- on reset.

Top module: `uniform_vec_assembler`

## Requirements
- R1: After reset, rf_we and idx_err are 0, the sequencer is in S_EMPTY and the index is 0, so the first commit writes entry 0.
- R2: With mode_f32=1, the fourth accepted word commits a vector. rf_we is 1 for exactly one cycle, in the cycle after the edge that accepts that word. Before that word, rf_we stays 0.
- R3: With mode_f32=0, the third accepted word commits a vector, with the same one-cycle timing as R2.
- R4: rf_data packs lanes as x=[23:0], y=[47:24], z=[71:48], w=[95:72]. In float mode the first word received lands in w, the second in z, the third in y and the fourth in x.
- R5: In packed mode, with words a, b, c in arrival order: w=a[31:8], z={a[7:0],b[31:16]}, y={b[15:0],c[31:24]}, x=c[23:0].
- R6: The 24-bit float is sign[23], exponent[22:16] with bias 63, and mantissa[15:0]. An input with biased exponent e of 64 or less becomes a signed zero (sign kept, all other bits 0). An input with e of 192 or more, including infinity and NaN, becomes {sign,7'h7F,16'hFFFF}. Any other input becomes {sign, e-64, mantissa[22:7]}.
- R7: idx_load sets the index to idx_value. Each valid commit advances the index by one, so back-to-back vectors go to consecutive rf_addr values, across mode changes between vectors.
- R8: A commit with index 96 or more gives rf_we=0 and a one-cycle idx_err pulse, and it leaves the index unchanged.
- R9: idx_load returns the sequencer to S_EMPTY and drops the words collected so far. A word presented in the same cycle as idx_load is ignored.
- R10: Cycles with wr_en=0 accept nothing, so idle gaps between words do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Data word strobe |
| wr_data | input | 32 | Data word |
| mode_f32 | input | 1 | 1: float words, four per vector; 0: packed, three per vector |
| idx_load | input | 1 | Load index from idx_value and clear the partial vector |
| idx_value | input | 7 | New destination index |
| rf_we | output | 1 | Register file write enable |
| rf_addr | output | 7 | Register file entry |
| rf_data | output | 96 | Vector written, lanes w,z,y,x from high to low |
| idx_err | output | 1 | Pulse: commit to an index outside the file |

## Verification
The float sweep walks the biased exponent through all 256 values, with varied mantissa and alternating sign. This separates the zero-flush, saturate and normal paths of the converter, and it also catches a reversed lane order. Packed vectors carry hashed words, so any slip in the field boundaries that cross words shows up in rf_data. The index is walked from 0 through 95 across both modes, then pushed to 96 and 127. Two commits in a row at 127 show whether a rejected commit wrongly advanced the index, because an advance would wrap to entry 0. Idle gaps, a load in the middle of a vector, and a load in the same cycle as a word separate true word counting from edge counting.

// File: rtl/uvec_pkg.sv
package uvec_pkg;
    localparam int WORD_W = 32;
    localparam int COMP_W = 24;
    localparam int LANES  = 4;
    localparam int VEC_W  = COMP_W * LANES;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_HAVE1 = 2'd1,
        S_HAVE2 = 2'd2,
        S_HAVE3 = 2'd3
    } fill_e;
endpackage

// File: rtl/uvec_f32_to_f24.sv
module uvec_f32_to_f24
    import uvec_pkg::*;
(
    input  logic [WORD_W-1:0] f_in,
    output logic [COMP_W-1:0] f_out
);
    localparam logic [7:0] LOW_LIMIT  = 8'd64;   // 127 - 63
    localparam logic [7:0] HIGH_LIMIT = 8'd192;  // first exponent past the range

    logic       sgn;
    logic [7:0] exp8;
    logic [7:0] exp_adj;

    always_comb begin
        sgn     = f_in[31];
        exp8    = f_in[30:23];
        exp_adj = exp8 - LOW_LIMIT;
        if (exp8 <= LOW_LIMIT)
            f_out = {sgn, 23'd0};
        else if (exp8 >= HIGH_LIMIT)
            f_out = {sgn, 7'h7F, 16'hFFFF};
        else
            f_out = {sgn, exp_adj[6:0], f_in[22:7]};
    end
endmodule

// File: rtl/uvec_fill_seq.sv
module uvec_fill_seq
    import uvec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       idx_load,
    input  logic       mode_f32,
    output logic [1:0] slot,
    output logic       accept,
    output logic       last
);
    fill_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        accept  = wr_en && !idx_load;
        state_d = state_q;
        if (idx_load) begin
            state_d = S_EMPTY;
        end else if (accept) begin
            unique case (state_q)
                S_EMPTY: state_d = S_HAVE1;
                S_HAVE1: state_d = S_HAVE2;
                S_HAVE2: state_d = mode_f32 ? S_HAVE3 : S_EMPTY;
                S_HAVE3: state_d = S_EMPTY;
                default: state_d = S_EMPTY;
            endcase
        end
    end

    always_comb begin
        slot = state_q;
        last = accept && ((state_q == S_HAVE3) || (state_q == S_HAVE2 && !mode_f32));
    end

    assert_commit_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> state_q == S_EMPTY);
    assert_load_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idx_load |=> state_q == S_EMPTY);
endmodule

// File: rtl/uniform_vec_assembler.sv
module uniform_vec_assembler
    import uvec_pkg::*;
#(
    parameter int ENTRIES = 96,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              mode_f32,
    input  logic              idx_load,
    input  logic [IDX_W-1:0]  idx_value,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_addr,
    output logic [VEC_W-1:0]  rf_data,
    output logic              idx_err
);
    localparam int HELD = LANES - 1;

    logic [1:0]        slot;
    logic              accept, last, idx_ok;
    logic [WORD_W-1:0] buf_q  [HELD];
    logic [WORD_W-1:0] word_v [LANES];
    logic [COMP_W-1:0] conv_v [LANES];
    logic [VEC_W-1:0]  vec_f32, vec_packed, vec_sel;
    logic [IDX_W-1:0]  idx_q;

    uvec_fill_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .idx_load (idx_load),
        .mode_f32 (mode_f32),
        .slot     (slot),
        .accept   (accept),
        .last     (last)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            if (g < HELD) begin : g_held
                assign word_v[g] = (slot == 2'(g)) ? wr_data : buf_q[g];
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)                            buf_q[g] <= '0;
                    else if (accept && slot == 2'(g))      buf_q[g] <= wr_data;
                end
            end else begin : g_tail
                assign word_v[g] = wr_data;
            end
            uvec_f32_to_f24 u_cvt (.f_in(word_v[g]), .f_out(conv_v[g]));
            // first word lands in the top lane (w), last in x
            assign vec_f32[VEC_W-1-g*COMP_W -: COMP_W] = conv_v[g];
        end
    endgenerate

    assign vec_packed = {word_v[0], word_v[1], word_v[2]};
    assign vec_sel    = mode_f32 ? vec_f32 : vec_packed;
    assign idx_ok     = ({1'b0, idx_q} < (IDX_W+1)'(ENTRIES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            rf_we   <= 1'b0;
            idx_err <= 1'b0;
            rf_addr <= '0;
            rf_data <= '0;
        end else begin
            rf_we   <= last && idx_ok;
            idx_err <= last && !idx_ok;
            if (idx_load) begin
                idx_q <= idx_value;
            end else if (last && idx_ok) begin
                idx_q   <= idx_q + 1'b1;
                rf_addr <= idx_q;
                rf_data <= vec_sel;
            end
        end
    end

    assert_addr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ({1'b0, rf_addr} < (IDX_W+1)'(ENTRIES)));
    assert_we_err_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && idx_err));
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);
    assert_index_advanced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> idx_q == rf_addr + 1'b1);
    assert_err_index_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err && !$past(idx_load) |-> ({1'b0, idx_q} >= (IDX_W+1)'(ENTRIES)));
endmodule

// File: tb/uniform_vec_assembler_bench.sv
`timescale 1ns/1ps
module uniform_vec_assembler_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        mode_f32 = 1'b1;
    logic        idx_load = 1'b0;
    logic [6:0]  idx_value = '0;
    logic        rf_we;
    logic [6:0]  rf_addr;
    logic [95:0] rf_data;
    logic        idx_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uniform_vec_assembler u_uniform_vec_assembler (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode_f32(mode_f32), .idx_load(idx_load), .idx_value(idx_value),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data), .idx_err(idx_err)
    );

    function automatic logic [23:0] ref_f24(input logic [31:0] f);
        int e;
        e = int'(f[30:23]);
        if (e <= 64)       return {f[31], 23'd0};
        else if (e >= 192) return {f[31], 7'h7F, 16'hFFFF};
        else               return {f[31], 7'(e - 64), f[22:7]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic load_idx(input logic [6:0] v);
        @(negedge clk);
        idx_load = 1'b1; idx_value = v;
        @(posedge clk); #1;
        idx_load = 1'b0;
    endtask

    // n words; checks quiet outputs before the last word, result after it
    task automatic send_vec(input logic [31:0] w [4], input int n, input int gap,
                            input bit exp_we, input logic [6:0] exp_addr,
                            input logic [95:0] exp_data, input string req);
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < gap; k++) begin
                @(negedge clk); // R10 idle cycle
            end
            put(w[i]);
            if (i < n-1)
                chk(!rf_we && !idx_err, req, "early commit", {94'd0, rf_we, idx_err}, 96'd0);
        end
        chk(rf_we == exp_we, req, "rf_we", 96'(rf_we), 96'(exp_we));
        chk(idx_err == !exp_we, req, "idx_err (R8)", 96'(idx_err), 96'(!exp_we));
        if (exp_we) begin
            chk(rf_addr == exp_addr, req, "rf_addr (R7)", 96'(rf_addr), 96'(exp_addr));
            chk(rf_data == exp_data, req, "rf_data", rf_data, exp_data);
        end
        @(posedge clk); #1;
        chk(!rf_we && !idx_err, req, "pulse width (R2)", {94'd0, rf_we, idx_err}, 96'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w [4];
        logic [95:0] exp;
        repeat (3) @(posedge clk);
        #1;
        chk(!rf_we && !idx_err, "R1", "reset outputs", {94'd0, rf_we, idx_err}, 96'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!rf_we && !idx_err, "R1", "after reset", {94'd0, rf_we, idx_err}, 96'd0);

        // R1 R2 R4 R6 R10: float sweep over all 256 exponents, entries 0..63
        mode_f32 = 1'b1;
        for (int v = 0; v < 64; v++) begin
            for (int i = 0; i < 4; i++) begin
                logic [7:0] e;
                e = 8'(v*4 + i);
                w[i] = {1'((v + i) & 1), e, e, ~e, 7'(v)};
            end
            exp = {ref_f24(w[0]), ref_f24(w[1]), ref_f24(w[2]), ref_f24(w[3])};
            send_vec(w, 4, (v % 5 == 0) ? 2 : 0, 1'b1, 7'(v), exp, "R2 R4 R6");
        end

        // R3 R5 R7: packed mode continues at entry 64..95
        mode_f32 = 1'b0;
        for (int v = 0; v < 32; v++) begin
            for (int i = 0; i < 3; i++) w[i] = 32'h9E3779B9 * 32'(v*3 + i + 1);
            w[3] = '0;
            exp = {w[0][31:8], {w[0][7:0], w[1][31:16]}, {w[1][15:0], w[2][31:24]}, w[2][23:0]};
            send_vec(w, 3, (v % 7 == 3) ? 1 : 0, 1'b1, 7'(64 + v), exp, "R3 R5 R7");
        end

        // R8: index reached 96; rejected twice
        w[0] = 32'h11111111; w[1] = 32'h22222222; w[2] = 32'h33333333; w[3] = '0;
        send_vec(w, 3, 0, 1'b0, '0, '0, "R8 idx96");
        send_vec(w, 3, 0, 1'b0, '0, '0, "R8 idx96 again");
        // R8: 127 must not wrap to 0 after a rejection
        load_idx(7'd127);
        send_vec(w, 3, 0, 1'b0, '0, '0, "R8 idx127");
        send_vec(w, 3, 0, 1'b0, '0, '0, "R8 idx127 no advance");
        // R7: last valid entry
        load_idx(7'd95);
        exp = {w[0][31:8], {w[0][7:0], w[1][31:16]}, {w[1][15:0], w[2][31:24]}, w[2][23:0]};
        send_vec(w, 3, 0, 1'b1, 7'd95, exp, "R7 idx95");

        // R9: load in the middle of a float vector discards partial words
        mode_f32 = 1'b1;
        load_idx(7'd5);
        put(32'hC0000000);
        put(32'h40490FDB);
        load_idx(7'd10);
        w[0] = 32'h3F800000; w[1] = 32'hBF800000; w[2] = 32'h7F800000; w[3] = 32'h00000001;
        exp = {ref_f24(w[0]), ref_f24(w[1]), ref_f24(w[2]), ref_f24(w[3])};
        send_vec(w, 4, 0, 1'b1, 7'd10, exp, "R9 mid-vector load");

        // R9: word together with idx_load is dropped
        mode_f32 = 1'b0;
        @(negedge clk);
        idx_load = 1'b1; idx_value = 7'd20; wr_en = 1'b1; wr_data = 32'hDEADBEEF;
        @(posedge clk); #1;
        idx_load = 1'b0; wr_en = 1'b0;
        chk(!rf_we, "R9", "no commit on load", 96'(rf_we), 96'd0);
        w[0] = 32'h01234567; w[1] = 32'h89ABCDEF; w[2] = 32'hFEDCBA98; w[3] = '0;
        exp = {w[0][31:8], {w[0][7:0], w[1][31:16]}, {w[1][15:0], w[2][31:24]}, w[2][23:0]};
        send_vec(w, 3, 0, 1'b1, 7'd20, exp, "R9 same-cycle word ignored");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule